// File: doc/BRIEF.md
# Flagged Integer Sum Unit

This block adds two 32-bit operands and an optional incoming carry, registers the sum, and keeps a small status state: a carry flag, an overflow flag, a sticky summary-overflow flag and a 4-bit condition field. Each issued operation carries its own control bits. These bits say whether the carry flag is rewritten, whether the overflow flags are rewritten and whether the condition field is rewritten. Any flag the bits do not select keeps its old value.

The first operand is either a register value or the constant zero. The constant is used when zero substitution is requested and the source index is 0. The second operand is either a register value or a 16-bit immediate, sign-extended to 32 bits. A separate write port loads the three status flags directly. This is the only way, apart from reset, to clear the summary-overflow flag.

An operation presented with `issue_valid` high is captured on the next rising clock edge. Its result and its flag updates are visible after that edge.

Top module: `int_sum_unit`

## Requirements
- R1: One cycle after an issue, `result` equals the 32-bit sum (modulo 2^32) of the effective first operand, the effective second operand and the carry term. `result_valid` is high in that cycle and low in a cycle that follows no issue.
- R2: The carry term is the current carry flag when `use_ca_in` is 1, and 0 otherwise.
- R3: When `calc_ca` is 1, the carry flag takes the carry out of bit 31 of the addition. When `calc_ca` is 0, the carry flag is unchanged.
- R4: When `oe` is 1, the overflow flag takes the 32-bit two's-complement overflow of the addition. When `oe` is 0, both the overflow flag and the summary-overflow flag are unchanged.
- R5: The summary-overflow flag is set whenever an operation sets the overflow flag. An operation that clears the overflow flag leaves the summary-overflow flag unchanged.
- R6: When `rc` is 1, the condition field becomes {LT, GT, EQ, SO} with bit 3 = LT. LT, GT and EQ come from a signed comparison of the result with zero, so exactly one of them is set. SO is the summary-overflow value after this cycle's update.
- R7: When `rc` is 0, or when no operation is issued, the condition field is unchanged.
- R8: When `sel_zero_sub` is 1 and `src_a_idx` is 0, the first operand is 0 regardless of `src_a_val`. In every other case the first operand is `src_a_val`.
- R9: When `use_imm` is 1, the second operand is `imm` sign-extended from bit 15, and `src_b_val` is ignored.
- R10: A synchronous active-high `rst` clears the carry flag, the overflow flag, the summary-overflow flag, the condition field and `result_valid`.
- R11: When `flag_wr_en` is 1, the next state of the flags is loaded from `flag_wr_val`, with bit 2 = SO, bit 1 = OV and bit 0 = CA. This load takes priority over an operation's updates to those flags in the same cycle.
- R12: When no operation is issued and no flag write is made, the carry, overflow and summary-overflow flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation present this cycle |
| sel_zero_sub | input | 1 | Allow index-zero substitution of the first operand |
| src_a_idx | input | 5 | Register index of the first operand |
| src_a_val | input | 32 | Register value of the first operand |
| src_b_val | input | 32 | Register value of the second operand |
| imm | input | 16 | Signed immediate |
| use_imm | input | 1 | Second operand is the sign-extended immediate |
| use_ca_in | input | 1 | Add the current carry flag |
| calc_ca | input | 1 | Rewrite the carry flag |
| oe | input | 1 | Rewrite the overflow flags |
| rc | input | 1 | Rewrite the condition field |
| flag_wr_en | input | 1 | Direct load of the flags |
| flag_wr_val | input | 3 | Flag load value {SO, OV, CA} |
| result | output | 32 | Registered sum |
| result_valid | output | 1 | Result updated by the previous cycle's issue |
| ca | output | 1 | Carry flag |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Summary-overflow flag |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Two functions can act in the same cycle: the overflow update (`oe`) and the condition-field update (`rc`). When they coincide, the SO bit written into the condition field must already reflect this cycle's overflow. The bench provokes this by sweeping every combination of `oe` and `rc` over operand pairs that do and do not overflow, and by running these sweeps while SO is still clear. It also collides a direct flag write with an issued operation, and checks that the condition field picks up the written SO value.

// File: rtl/int_sum_unit.sv
module int_sum_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic             sel_zero_sub,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [WIDTH-1:0] src_a_val,
  input  logic [WIDTH-1:0] src_b_val,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             use_ca_in,
  input  logic             calc_ca,
  input  logic             oe,
  input  logic             rc,
  input  logic             flag_wr_en,
  input  logic [2:0]       flag_wr_val,
  output logic [WIDTH-1:0] result,
  output logic             result_valid,
  output logic             ca,
  output logic             ov,
  output logic             so,
  output logic [3:0]       cond
);

  localparam int EXT_W = WIDTH - IMM_W;
  localparam int MSB   = WIDTH - 1;

  logic [WIDTH-1:0] opa, opb, sum;
  logic             cin, cout, ovf;
  logic             ca_nxt, ov_nxt, so_nxt;
  logic [3:0]       cond_nxt;

  assign opa = (sel_zero_sub && src_a_idx == '0) ? '0 : src_a_val;
  assign opb = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : src_b_val;
  assign cin = use_ca_in & ca;

  assign {cout, sum} = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
  assign ovf = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);

  always_comb begin
    ca_nxt = ca;
    ov_nxt = ov;
    so_nxt = so;
    if (flag_wr_en) begin
      ca_nxt = flag_wr_val[0];
      ov_nxt = flag_wr_val[1];
      so_nxt = flag_wr_val[2];
    end else if (issue_valid) begin
      if (calc_ca) ca_nxt = cout;
      if (oe) begin
        ov_nxt = ovf;
        so_nxt = so | ovf;
      end
    end
  end

  assign cond_nxt = {sum[MSB], !sum[MSB] && (|sum), ~|sum, so_nxt};

  always_ff @(posedge clk) begin
    if (rst) begin
      ca           <= 1'b0;
      ov           <= 1'b0;
      so           <= 1'b0;
      cond         <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      ca           <= ca_nxt;
      ov           <= ov_nxt;
      so           <= so_nxt;
      result_valid <= issue_valid;
      if (issue_valid) begin
        result <= sum;
        if (rc) cond <= cond_nxt;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !ca && !ov && !so && cond == 4'b0 && !result_valid); // R10

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    so && !flag_wr_en |=> so); // R5

  AST_OV_IMPLIES_SO: assert property (@(posedge clk) disable iff (rst)
    issue_valid && oe && !flag_wr_en |=> (!ov || so)); // R5

  AST_NO_OE_KEEP: assert property (@(posedge clk) disable iff (rst)
    issue_valid && !oe && !flag_wr_en |=> $stable({ov, so})); // R4

  AST_NO_CA_KEEP: assert property (@(posedge clk) disable iff (rst)
    issue_valid && !calc_ca && !flag_wr_en |=> $stable(ca)); // R3

  AST_COND_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    issue_valid && rc |=> $countones(cond[3:1]) == 1); // R6

  AST_COND_SO_MATCH: assert property (@(posedge clk) disable iff (rst)
    issue_valid && rc |=> cond[0] == so); // R6

  AST_NO_RC_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid && rc) |=> $stable(cond)); // R7

  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !issue_valid && !flag_wr_en |=> $stable({ca, ov, so})); // R12

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    flag_wr_en |=> {so, ov, ca} == $past(flag_wr_val)); // R11

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> result_valid); // R1

endmodule

// File: tb/sim_int_sum_unit.sv
module sim_int_sum_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid, sel_zero_sub, use_imm, use_ca_in, calc_ca, oe, rc, flag_wr_en;
  logic [4:0]  src_a_idx;
  logic [31:0] src_a_val, src_b_val;
  logic [15:0] imm;
  logic [2:0]  flag_wr_val;
  logic [31:0] result;
  logic        result_valid, ca, ov, so;
  logic [3:0]  cond;

  int tests = 0;
  int fails = 0;

  logic       m_ca, m_ov, m_so;
  logic [3:0] m_cond;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_sum_unit u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .sel_zero_sub(sel_zero_sub),
    .src_a_idx(src_a_idx), .src_a_val(src_a_val), .src_b_val(src_b_val), .imm(imm),
    .use_imm(use_imm), .use_ca_in(use_ca_in), .calc_ca(calc_ca), .oe(oe), .rc(rc),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val), .result(result),
    .result_valid(result_valid), .ca(ca), .ov(ov), .so(so), .cond(cond)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue_valid = 0; sel_zero_sub = 0; use_imm = 0; use_ca_in = 0; calc_ca = 0;
    oe = 0; rc = 0; flag_wr_en = 0; flag_wr_val = 3'b000;
    src_a_idx = 5'd3; src_a_val = '0; src_b_val = '0; imm = '0;
  endtask

  task automatic op(input logic [31:0] a, input logic [4:0] idx, input bit zs,
                    input logic [31:0] b, input logic [15:0] im, input bit ui,
                    input bit uc, input bit cc, input bit o, input bit r,
                    input bit we, input logic [2:0] wv, input string tag);
    logic [31:0] ea, eb, sres;
    logic [32:0] full;
    longint      sv;
    bit          c, v;
    @(negedge clk);
    issue_valid = 1; src_a_val = a; src_a_idx = idx; sel_zero_sub = zs;
    src_b_val = b; imm = im; use_imm = ui; use_ca_in = uc; calc_ca = cc;
    oe = o; rc = r; flag_wr_en = we; flag_wr_val = wv;
    ea = (zs && idx == 5'd0) ? 32'd0 : a;
    eb = ui ? {{16{im[15]}}, im} : b;
    c = uc ? m_ca : 1'b0;
    full = {1'b0, ea} + {1'b0, eb} + {32'd0, c};
    sres = full[31:0];
    sv = longint'($signed(ea)) + longint'($signed(eb)) + longint'(c);
    v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    if (we) begin
      m_ca = wv[0]; m_ov = wv[1]; m_so = wv[2];
    end else begin
      if (cc) m_ca = full[32];
      if (o) begin m_ov = v; if (v) m_so = 1'b1; end
    end
    if (r) m_cond = {$signed(sres) < 0, $signed(sres) > 0, sres == 32'd0, m_so};
    @(negedge clk);
    issue_valid = 0; flag_wr_en = 0;
    check(result == sres, tag, result, sres);
    check(result_valid == 1'b1, "R12 R1 valid", {31'd0, result_valid}, 32'd1);
    check(ca == m_ca, cc ? "R3 ca update" : "R3 ca keep", {31'd0, ca}, {31'd0, m_ca});
    check(ov == m_ov, we ? "R11 ov" : "R4 ov", {31'd0, ov}, {31'd0, m_ov});
    check(so == m_so, we ? "R11 so" : "R5 so", {31'd0, so}, {31'd0, m_so});
    check(cond == m_cond, r ? "R6 cond" : "R7 cond keep", {28'd0, cond}, {28'd0, m_cond});
  endtask

  task automatic flag_write(input logic [2:0] wv);
    @(negedge clk);
    flag_wr_en = 1; flag_wr_val = wv;
    m_ca = wv[0]; m_ov = wv[1]; m_so = wv[2];
    @(negedge clk);
    flag_wr_en = 0;
    check({so, ov, ca} == wv, "R11 write", {29'd0, so, ov, ca}, {29'd0, wv});
    check(result_valid == 1'b0, "R1 no valid", {31'd0, result_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] corners [8];
    logic [15:0] imms [6];
    corners = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff,
                32'h12345678, 32'h80000001, 32'hfffffffe};
    imms = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
    idle_inputs();
    rst = 1'b1;
    src_a_val = 32'hdeadbeef;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({ca, ov, so} == 3'b000, "R10 flags", {29'd0, ca, ov, so}, 32'd0);
    check(cond == 4'd0, "R10 cond", {28'd0, cond}, 32'd0);
    check(result_valid == 1'b0, "R10 valid", {31'd0, result_valid}, 32'd0);
    m_ca = 0; m_ov = 0; m_so = 0; m_cond = '0;
    repeat (2) @(negedge clk);
    check({ca, ov, so} == 3'b000, "R12 idle", {29'd0, ca, ov, so}, 32'd0);

    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          if (j == 0 && (i % 4) == 0) flag_write({1'b0, ctl[0], ~ctl[0]});
          op(corners[i], 5'd7, 1'b1, corners[j], 16'h0, 1'b0,
             ctl[0], ctl[1], ctl[2], ctl[3], 1'b0, 3'b000,
             ctl[0] ? "R2 sum with carry" : "R1 sum");
        end
      end
    end

    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 6; k++) begin
        op(corners[i], 5'd0, 1'b1, 32'h5a5a5a5a, imms[k], 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
           1'b0, 3'b000, "R8 R9 zero sub imm");
        op(corners[i], 5'd0, 1'b0, 32'h5a5a5a5a, imms[k], 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
           1'b0, 3'b000, "R8 idx0 no sub");
        op(corners[i], 5'd9, 1'b1, 32'ha5a5a5a5, imms[k], 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
           1'b0, 3'b000, "R9 imm sext");
      end
    end

    flag_write(3'b000);
    op(32'h7fffffff, 5'd2, 1'b0, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
       1'b0, 3'b000, "R6 same-cycle ov and cond");
    check(cond[0] == 1'b1, "R6 cond so after ov", {31'd0, cond[0]}, 32'd1);
    op(32'h1, 5'd2, 1'b0, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
       1'b0, 3'b000, "R5 clear ov keeps so");
    check(so == 1'b1, "R5 so sticky", {31'd0, so}, 32'd1);
    op(32'h7fffffff, 5'd2, 1'b0, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
       1'b1, 3'b001, "R11 write vs op");
    check(cond[0] == 1'b0, "R11 cond takes written so", {31'd0, cond[0]}, 32'd0);
    flag_write(3'b111);
    flag_write(3'b000);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({ca, ov, so, cond} == 7'd0, "R10 reset again", {25'd0, ca, ov, so, cond}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule